// File: doc/BRIEF.md
# Shared-Window Serial Port Address Decoder and Interrupt Combiner

This block is the glue between a host I/O bus and a bank of four or eight serial controllers. The controllers occupy one contiguous, naturally aligned I/O window whose position is set by a 16-bit base input. Every controller takes eight consecutive byte locations. The block compares the full 16-bit host address against the base. On a hit it raises one per-port chip select and passes a 3-bit register offset to the controller.

The block also merges the per-port interrupt requests into a single level-held request line. A port's request counts only while that port's interrupt-enable output (the modem-control output used as the external interrupt gate) is active. A static configuration input can enable a read-only status byte. When enabled, the status byte takes the place of offset 7 of every port, which is otherwise the controller's scratchpad. The byte shows which ports have a request pending. The bus can write to the status location to ask for a fresh edge on the request line while requests remain, so an edge-triggered host interrupt controller does not miss work left over.

The bus side is a plain read strobe and write strobe with an address. The block only routes; the controllers' data paths are outside it.

Top module: `mpio_decode`

## Requirements
- R1: An access hits the block only when address bits 15 down to log2(8*NUM_PORTS) equal the same bits of `cfg_base` (bits 15..5 with four ports, 15..6 with eight). An access outside the block drives no port select and no status select.
- R2: On a hit that is not routed to the status byte, exactly one `port_sel` bit is high. The bit is the one indexed by address bits log2(8*NUM_PORTS)-1 down to 3, so port n covers base+8n through base+8n+7. `reg_off` always equals address bits 2..0.
- R3: With `cfg_stat_en` high, any hit with offset 7, whether a read or a write, raises `stat_sel` and no `port_sel` bit.
- R4: With `cfg_stat_en` low, offset 7 selects the port like any other offset, and `stat_sel` stays low.
- R5: `stat_rdata` bit k equals `port_irq[k]` for every k below NUM_PORTS. Bits at NUM_PORTS and above read 0.
- R6: `irq_out` is registered. One clock after any port has an enabled request, it is high. One clock after no port has one, it is low.
- R7: A port's request reaches `irq_out` only while its `port_out2` bit is 1. `stat_rdata` shows the raw request regardless of `port_out2`.
- R8: A write to the status location while an enabled request exists forces `irq_out` low on the next clock. If requests remain, the line rises again on the clock after that. A status write with no enabled request changes nothing.
- R9: A read of the status location has no effect on `irq_out`.
- R10: With neither `bus_rd` nor `bus_wr` high, all port selects and `stat_sel` are low.
- R11: While `rst` is high and on the first clock after it, `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 16 | Window base address (low bits ignored) |
| cfg_stat_en | input | 1 | Static enable for the status byte at offset 7 |
| bus_addr | input | 16 | Host I/O address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| port_irq | input | NUM_PORTS | Per-port interrupt request |
| port_out2 | input | NUM_PORTS | Per-port interrupt gate output of each controller |
| port_sel | output | NUM_PORTS | One-hot controller chip select |
| reg_off | output | 3 | Register offset inside the 8-byte window |
| stat_sel | output | 1 | Status byte selected (read drives `stat_rdata`, write retriggers) |
| stat_rdata | output | 8 | Status byte, one bit per port |
| irq_out | output | 1 | Shared, level-held interrupt request |

## Verification
The bench builds two instances side by side on the same stimulus: one with NUM_PORTS = 8 and one with NUM_PORTS = 4. Because the 4-port window is half as wide, the same addresses act as both in-window and out-of-window accesses. This exercises the different match widths of R1 and the zero upper status bits of R5. Requests raised only on ports 4..7 show that the smaller build neither reports them nor retriggers on them. Both window bases sit at aligned positions with high address bits set, so a decode that drops upper bits is caught.

// File: rtl/mpio_pkg.sv
package mpio_pkg;

    localparam int ADDR_W   = 16;
    localparam int OFF_W    = 3;
    localparam int STAT_W   = 8;
    localparam logic [OFF_W-1:0] STAT_OFF = 3'd7;

    typedef struct packed {
        logic             hit;
        logic             to_stat;
        logic [OFF_W-1:0] off;
    } dec_t;

    // Number of low address bits covered by the whole window.
    function automatic int win_bits(input int nports);
        return $clog2(nports) + OFF_W;
    endfunction

    // Whether an in-window access at this offset goes to the status byte.
    function automatic logic routes_to_stat(input logic en, input logic [OFF_W-1:0] off);
        return en && (off == STAT_OFF);
    endfunction

endpackage

// File: rtl/mpio_addr_dec.sv
module mpio_addr_dec
    import mpio_pkg::*;
#(
    parameter int NUM_PORTS = 8
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               stat_en,
    input  logic               rd,
    input  logic               wr,
    output logic [NUM_PORTS-1:0] sel,
    output logic [OFF_W-1:0]   off,
    output logic               stat_sel
);
    localparam int LOW   = win_bits(NUM_PORTS);
    localparam int IDX_W = $clog2(NUM_PORTS);

    dec_t             d;
    logic [IDX_W-1:0] idx;

    always_comb begin
        d.hit     = (rd || wr) && (addr[ADDR_W-1:LOW] == base[ADDR_W-1:LOW]);
        d.off     = addr[OFF_W-1:0];
        d.to_stat = routes_to_stat(stat_en, d.off);
        idx       = addr[LOW-1:OFF_W];
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_sel
        assign sel[g] = d.hit && !d.to_stat && (idx == IDX_W'(g));
    end

    assign off      = d.off;
    assign stat_sel = d.hit && d.to_stat;

endmodule

// File: rtl/mpio_stat_byte.sv
module mpio_stat_byte
    import mpio_pkg::*;
#(
    parameter int NUM_PORTS = 8
) (
    input  logic [NUM_PORTS-1:0] req,
    output logic [STAT_W-1:0]    stat
);
    for (genvar k = 0; k < STAT_W; k++) begin : g_bit
        if (k < NUM_PORTS) begin : g_live
            assign stat[k] = req[k];
        end else begin : g_zero
            assign stat[k] = 1'b0;
        end
    end
endmodule

// File: rtl/mpio_irq_merge.sv
module mpio_irq_merge #(
    parameter int NUM_PORTS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PORTS-1:0] req,
    input  logic [NUM_PORTS-1:0] gate,
    input  logic                 stat_wr,
    output logic                 irq
);
    logic any_req;
    logic retrig;

    assign any_req = |(req & gate);
    assign retrig  = stat_wr && any_req;

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= any_req && !retrig;
    end
endmodule

// File: rtl/mpio_decode.sv
module mpio_decode
    import mpio_pkg::*;
#(
    parameter int NUM_PORTS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [15:0]          cfg_base,
    input  logic                 cfg_stat_en,
    input  logic [15:0]          bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [NUM_PORTS-1:0] port_irq,
    input  logic [NUM_PORTS-1:0] port_out2,
    output logic [NUM_PORTS-1:0] port_sel,
    output logic [2:0]           reg_off,
    output logic                 stat_sel,
    output logic [7:0]           stat_rdata,
    output logic                 irq_out
);
    mpio_addr_dec #(.NUM_PORTS(NUM_PORTS)) u_dec (
        .base     (cfg_base),
        .addr     (bus_addr),
        .stat_en  (cfg_stat_en),
        .rd       (bus_rd),
        .wr       (bus_wr),
        .sel      (port_sel),
        .off      (reg_off),
        .stat_sel (stat_sel)
    );

    mpio_stat_byte #(.NUM_PORTS(NUM_PORTS)) u_stat (
        .req  (port_irq),
        .stat (stat_rdata)
    );

    mpio_irq_merge #(.NUM_PORTS(NUM_PORTS)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .req     (port_irq),
        .gate    (port_out2),
        .stat_wr (stat_sel && bus_wr),
        .irq     (irq_out)
    );
endmodule

// File: rtl/mpio_decode_chk.sv
module mpio_decode_chk #(
    parameter int NUM_PORTS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_stat_en,
    input logic [15:0]          bus_addr,
    input logic                 bus_rd,
    input logic                 bus_wr,
    input logic [NUM_PORTS-1:0] port_irq,
    input logic [NUM_PORTS-1:0] port_out2,
    input logic [NUM_PORTS-1:0] port_sel,
    input logic                 stat_sel,
    input logic                 irq_out
);
    logic gated;
    logic stat_wr;
    assign gated   = |(port_irq & port_out2);
    assign stat_wr = bus_wr && stat_sel;

    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(port_sel));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd || bus_wr) |-> (port_sel == '0) && !stat_sel);

    p_stat_route_r3: assert property (@(posedge clk) disable iff (rst)
        stat_sel |-> cfg_stat_en && (bus_addr[2:0] == 3'd7) && (port_sel == '0));

    p_scratch_kept_r4: assert property (@(posedge clk) disable iff (rst)
        !cfg_stat_en |-> !stat_sel);

    p_irq_held_r6: assert property (@(posedge clk) disable iff (rst)
        (gated && !stat_wr) |=> irq_out);

    p_irq_drop_r6: assert property (@(posedge clk) disable iff (rst)
        !gated |=> !irq_out);

    p_retrig_low_r8: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && gated) |=> !irq_out);

    p_ungated_silent_r7: assert property (@(posedge clk) disable iff (rst)
        ((port_irq & port_out2) == '0) |=> !irq_out);
endmodule

bind mpio_decode mpio_decode_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_stat_en (cfg_stat_en),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .port_irq    (port_irq),
    .port_out2   (port_out2),
    .port_sel    (port_sel),
    .stat_sel    (stat_sel),
    .irq_out     (irq_out)
);

// File: tb/mpio_decode_tb.sv
module mpio_decode_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst;
    logic [15:0] base, addr;
    logic        sten, rd, wr;
    logic [7:0]  irq, out2;

    logic [7:0] sel8;  logic [3:0] sel4;
    logic [2:0] off8, off4;
    logic       st8, st4;
    logic [7:0] rd8, rd4;
    logic       irq8, irq4;

    mpio_decode #(.NUM_PORTS(8)) u_dut (
        .clk(clk), .rst(rst), .cfg_base(base), .cfg_stat_en(sten),
        .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
        .port_irq(irq), .port_out2(out2),
        .port_sel(sel8), .reg_off(off8), .stat_sel(st8),
        .stat_rdata(rd8), .irq_out(irq8));

    mpio_decode #(.NUM_PORTS(4)) u_dut4 (
        .clk(clk), .rst(rst), .cfg_base(base), .cfg_stat_en(sten),
        .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
        .port_irq(irq[3:0]), .port_out2(out2[3:0]),
        .port_sel(sel4), .reg_off(off4), .stat_sel(st4),
        .stat_rdata(rd4), .irq_out(irq4));

    int checks = 0;
    int errors = 0;

    // Behavioural reference: integer window arithmetic.
    function automatic void model(input int np, output logic [7:0] sel,
                                  output logic st, output string lab);
        int blk = np * 8;
        int a = int'(addr);
        int b = int'(base);
        sel = '0; st = 1'b0;
        if (!(rd || wr))               lab = "R10";
        else if ((a / blk) != (b / blk)) lab = "R1";
        else if ((a % 8) == 7 && sten) begin st = 1'b1; lab = "R3"; end
        else begin
            sel[(a % blk) / 8] = 1'b1;
            lab = ((a % 8) == 7) ? "R4" : "R2";
        end
    endfunction

    function automatic logic any_req(input int np);
        logic r = 1'b0;
        for (int k = 0; k < np; k++) r |= irq[k] & out2[k];
        return r;
    endfunction

    logic  exp8 = 1'b0, exp4 = 1'b0;
    string lab8 = "R11", lab4 = "R11";

    always @(posedge clk) begin
        logic [7:0] s; logic t8, t4; string l;
        model(8, s, t8, l);
        model(4, s, t4, l);
        if (rst) begin
            exp8 <= 1'b0; exp4 <= 1'b0; lab8 <= "R11"; lab4 <= "R11";
        end else begin
            exp8 <= any_req(8) && !(wr && t8);
            exp4 <= any_req(4) && !(wr && t4);
            lab8 <= (wr && t8 && any_req(8)) ? "R8" : (rd && t8) ? "R9" :
                    ((irq & ~out2) != 0) ? "R7" : "R6";
            lab4 <= (wr && t4 && any_req(4)) ? "R8" : (rd && t4) ? "R9" :
                    ((irq[3:0] & ~out2[3:0]) != 0) ? "R7" : "R6";
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic [7:0] s; logic t; string l; logic [7:0] er;
        model(8, s, t, l);
        chk(l, sel8, s, "sel8");
        chk(l, st8, t, "stat_sel8");
        model(4, s, t, l);
        chk(l, {4'b0, sel4}, s, "sel4");
        chk(l, st4, t, "stat_sel4");
        chk("R2", off8, addr[2:0], "reg_off8");
        chk("R2", off4, addr[2:0], "reg_off4");
        chk("R5", rd8, irq, "stat_rdata8");
        er = {4'b0, irq[3:0]};
        chk("R5", rd4, er, "stat_rdata4");
        chk(lab8, irq8, exp8, "irq_out8");
        chk(lab4, irq4, exp4, "irq_out4");
    end

    task automatic acc(input logic [15:0] a, input logic r, input logic w);
        @(posedge clk); #2;
        addr = a; rd = r; wr = w;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) acc(addr, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; base = 16'h5AC0; addr = 16'h0000; sten = 1'b1;
        rd = 1'b0; wr = 1'b0; irq = 8'h00; out2 = 8'h00;
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        idle(3);
        // R2 R3 R1: sweep every offset of the 8-port window (upper half is outside for 4 ports)
        for (int i = 0; i < 64; i++) acc(16'h5AC0 + 16'(i), 1'b1, 1'b0);
        for (int i = 0; i < 64; i += 5) acc(16'h5AC0 + 16'(i), 1'b0, 1'b1);
        // R1: just outside, and upper-bit aliases
        acc(16'h5ABF, 1'b1, 1'b0); acc(16'h5B00, 1'b1, 1'b0);
        acc(16'hDAC0, 1'b1, 1'b0); acc(16'h1AC7, 1'b0, 1'b1);
        // R4: scratchpad path when status disabled
        sten = 1'b0;
        for (int p = 0; p < 8; p++) acc(16'h5AC7 + 16'(p * 8), 1'b1, 1'b0);
        acc(16'h5AC7, 1'b0, 1'b1);
        sten = 1'b1;
        // R7: raw requests with gates closed
        irq = 8'h05; out2 = 8'h00; idle(3);
        acc(16'h5ACF, 1'b0, 1'b1);   // status write with no enabled request (R8)
        idle(2);
        // R6: gates open
        out2 = 8'hFF; idle(3);
        acc(16'h5AC7, 1'b1, 1'b0);   // R9 status read
        acc(16'h5AC7, 1'b1, 1'b0);
        idle(2);
        acc(16'h5AFF, 1'b0, 1'b1);   // R8 retrigger
        idle(3);
        acc(16'h5AD7, 1'b0, 1'b1);   // R8 back-to-back retrigger
        acc(16'h5AD7, 1'b0, 1'b1);
        idle(3);
        irq = 8'h00; idle(3);        // R6 deassert
        // request only on an upper port: 4-port build must not see it
        irq = 8'h40; idle(2);
        acc(16'h5AC7, 1'b0, 1'b1);
        idle(3);
        irq = 8'h00;
        // second base position
        base = 16'h0300; idle(1);
        for (int i = 0; i < 70; i++) acc(16'h02F8 + 16'(i), 1'b1, 1'b0);
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            @(posedge clk); #2;
            addr = 16'h02E0 + 16'($urandom_range(0, 127));
            rd   = 1'($urandom);
            wr   = !rd && ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 7) == 0) irq  = 8'($urandom);
            if ($urandom_range(0, 15) == 0) out2 = 8'($urandom);
            if ($urandom_range(0, 31) == 0) sten = !sten;
        end
        idle(3);
        // R11: reset mid-run with requests pending
        irq = 8'hFF; out2 = 8'hFF; idle(2);
        @(posedge clk); #2 rst = 1'b1;
        idle(3);
        @(posedge clk); #2 rst = 1'b0;
        idle(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule